// File: doc/BRIEF.md
# ECC Syndrome to DIMM Pin Locator

This block turns a corrected-error report into a physical location on the memory modules. It takes a syndrome code, the physical address of the failing access and the index of the bank whose decoder matched that address. From these it works out which DIMM of a four-module group holds the failing bit and which pin of that module carried it. A syndrome of -1 marks an uncorrectable multi-bit error. In that case the block reports the whole four-module group and no single pin.

The syndrome is first reordered into the bit order used on the memory bus. The quadword of the 64-byte line, taken from the address, then places that bit within the 576-bit line transfer (four quadwords of 144 bits). The result indexes two lookup tables. A packed selector table holds two bits per line position, and one bit of each pair picks the module. A pin table holds one entry per line position. There are two sets of tables, and a layout flag chooses between them. A single write port fills the tables. Each request gives one result two cycles later, and a new request may be accepted every cycle.

Top module: `ecc_pin_locator`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle with `loc_valid` high, two rising edges later. Back-to-back requests give back-to-back results in request order. After reset, `loc_valid`, `loc_unknown`, `loc_multi`, `loc_dimm` and `loc_pin` are all 0.
- R2: `req_syn` is a signed two's-complement 10-bit code. If `req_hit` is 0, or the code is below -1 or above 144, the result has `loc_unknown`=1, `loc_multi`=0, `loc_dimm`=0 and `loc_pin`=0.
- R3: A code of -1 with `req_hit`=1 gives `loc_multi`=1, `loc_unknown`=0, `loc_dimm` = 4 × `req_bank[0]` (the first module of the group) and `loc_pin`=0.
- R4: Codes are reordered to a bus bit as follows: 0..127 map to code+16, 128..143 map to code-137, and 144 maps to 1.
- R5: The quadword number q is `req_addr[5:4]`. The line bit is w = (3-q)×144 + bus bit, and the table position is p = 575 - w.
- R6: For a located error, `loc_dimm` = 4 × `req_bank[0]` + s. Here s is bit (3 - p mod 4)×2 of selector-table byte p/4 (integer division).
- R7: For a located error, `loc_pin` is pin-table entry w.
- R8: `sym_layout`=1, sampled with the request, selects table set 0. `sym_layout`=0 selects set 1.
- R9: A code whose bus bit falls outside 0..143 (codes 128..136) gives the unknown result of R2.
- R10: A write with `tbl_wr_en`=1 stores `tbl_wr_data` into the set given by `tbl_wr_set`. `tbl_wr_pin`=1 writes pin-table entry `tbl_wr_addr` (0..575). `tbl_wr_pin`=0 writes selector byte `tbl_wr_addr` (0..143). A write whose address lies beyond the chosen table is ignored and changes no entry.
- R11: Consider a table write driven in the cycle after a request is accepted, so that it lands on the same edge that reads the table for that request. That request returns the old contents, and a request accepted one cycle later returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_syn | input | 10 | Signed syndrome code, -1 marks a multi-bit error |
| req_addr | input | 40 | Physical address of the failing access |
| req_hit | input | 1 | A bank decoder matched the address |
| req_bank | input | 2 | Index of the matching bank |
| sym_layout | input | 1 | Layout flag: 1 selects table set 0, 0 selects set 1 |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_pin | input | 1 | 1 writes the pin table, 0 writes the selector table |
| tbl_wr_set | input | 1 | Table set written |
| tbl_wr_addr | input | 10 | Entry written |
| tbl_wr_data | input | 8 | Data written |
| loc_valid | output | 1 | Result strobe |
| loc_unknown | output | 1 | Location could not be resolved |
| loc_multi | output | 1 | Multi-bit error, the group is reported |
| loc_dimm | output | 3 | Module index (group base for a multi-bit error) |
| loc_pin | output | 8 | Pin number on that module |

## Verification
A table write can land on the same clock edge as the table read of a request already in flight. The bench provokes this on purpose. It issues a request and, in the next cycle, rewrites the pin entry that request will read. It then repeats the same request at once. The first result must carry the old entry and the second the new one. The bench tracks both by keeping its own shadow copy of every table and taking the expected value at the moment each request is issued. Apart from this case, the bench sweeps every code from -3 to 150 over all four quadwords and both layouts with back-to-back requests, so the pipeline is always full.

// File: rtl/ecc_loc_pkg.sv
package ecc_loc_pkg;

  // Outcome of a lookup, carried along the pipeline
  typedef enum logic [1:0] {
    LK_OK    = 2'd0,
    LK_MULTI = 2'd1,
    LK_UNK   = 2'd2
  } loc_kind_e;

endpackage

// File: rtl/ecc_syn_remap.sv
// Classifies a syndrome and maps it to a bit position in the line transfer.
module ecc_syn_remap
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W   = 10,
  parameter int QW_BITS = 144,
  parameter int QW_NUM  = 4,
  parameter int SYN_MAX = 144
) (
  input  logic signed [SYN_W-1:0]          syn,
  input  logic [$clog2(QW_NUM)-1:0]        qw,
  input  logic                             hit,
  output loc_kind_e                        kind,
  output logic [$clog2(QW_NUM*QW_BITS)-1:0] wil,
  output logic [$clog2(QW_NUM*QW_BITS)-1:0] where_pos
);

  localparam int LINE_BITS = QW_NUM * QW_BITS;
  localparam int POS_W     = $clog2(LINE_BITS);
  localparam int DATA_SPAN = QW_BITS - 16;

  int syn_i;
  int rem_i;
  int wil_i;

  always_comb begin
    syn_i = int'(syn);
    // reorder into bus bit order: data, then check bits, then tag bits
    if (syn_i < DATA_SPAN)         rem_i = syn_i + 16;
    else if (syn_i < QW_BITS)      rem_i = syn_i - (QW_BITS - 7);
    else if (syn_i < QW_BITS + 3)  rem_i = syn_i - (QW_BITS - 1);
    else                           rem_i = syn_i - (QW_BITS + 3);

    wil_i = (QW_NUM - 1 - int'(qw)) * QW_BITS + rem_i;

    if (!hit || syn_i < -1 || syn_i > SYN_MAX)  kind = LK_UNK;
    else if (syn_i == -1)                       kind = LK_MULTI;
    else if (rem_i < 0 || rem_i >= QW_BITS)     kind = LK_UNK;
    else                                        kind = LK_OK;

    if (kind == LK_OK) begin
      wil       = POS_W'(wil_i);
      where_pos = POS_W'(LINE_BITS - 1 - wil_i);
    end else begin
      wil       = '0;
      where_pos = '0;
    end
  end

endmodule

// File: rtl/ecc_loc_tables.sv
// Two loadable table sets: packed module selectors and pin numbers.
module ecc_loc_tables #(
  parameter int LINE_BITS = 576,
  parameter int SLOTS     = 4,
  parameter int SEL_BITS  = 2,
  parameter int DATA_W    = 8,
  parameter int NSETS     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_pin,
  input  logic [$clog2(NSETS)-1:0]      wr_set,
  input  logic [$clog2(LINE_BITS)-1:0]  wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [$clog2(NSETS)-1:0]      rd_set,
  input  logic [$clog2(LINE_BITS)-1:0]  rd_where,
  input  logic [$clog2(LINE_BITS)-1:0]  rd_wil,
  output logic                          rd_dimm_bit,
  output logic [DATA_W-1:0]             rd_pin
);

  localparam int POS_W     = $clog2(LINE_BITS);
  localparam int SET_W     = $clog2(NSETS);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int MAP_DEPTH = LINE_BITS / SLOTS;
  localparam int MAP_AW    = POS_W - SLOT_W;
  localparam int BIT_W     = $clog2(DATA_W);

  logic [DATA_W-1:0] set_map_byte [NSETS];
  logic [DATA_W-1:0] set_pin      [NSETS];

  for (genvar gs = 0; gs < NSETS; gs++) begin : g_set
    logic [DATA_W-1:0] map_mem [MAP_DEPTH];
    logic [DATA_W-1:0] pin_mem [LINE_BITS];
    logic              sel_here;

    assign sel_here = wr_en && (wr_set == SET_W'(gs));

    always_ff @(posedge clk) begin
      if (sel_here && !wr_pin && (wr_addr < POS_W'(MAP_DEPTH)))
        map_mem[wr_addr[MAP_AW-1:0]] <= wr_data;
      if (sel_here && wr_pin && (wr_addr < POS_W'(LINE_BITS)))
        pin_mem[wr_addr] <= wr_data;
    end

    assign set_map_byte[gs] = map_mem[rd_where[POS_W-1:SLOT_W]];
    assign set_pin[gs]      = pin_mem[rd_wil];
  end

  logic [DATA_W-1:0] map_byte;
  logic [BIT_W-1:0]  sel_idx;
  logic              dimm_bit_n;
  logic [DATA_W-1:0] pin_n;

  always_comb begin
    map_byte   = set_map_byte[rd_set];
    sel_idx    = BIT_W'((SLOTS - 1 - int'(rd_where[SLOT_W-1:0])) * SEL_BITS);
    dimm_bit_n = map_byte[sel_idx];
    pin_n      = set_pin[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_dimm_bit <= 1'b0;
      rd_pin      <= '0;
    end else if (rd_en) begin
      rd_dimm_bit <= dimm_bit_n;
      rd_pin      <= pin_n;
    end
  end

endmodule

// File: rtl/ecc_pin_locator.sv
// Top: two-stage syndrome-to-location pipeline.
module ecc_pin_locator
  import ecc_loc_pkg::*;
#(
  parameter int SYN_W         = 10,
  parameter int ADDR_W        = 40,
  parameter int BANK_W        = 2,
  parameter int QW_NUM        = 4,
  parameter int QW_BITS       = 144,
  parameter int LINE_BYTES    = 64,
  parameter int DIMMS_PER_GRP = 4,
  parameter int PIN_W         = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic signed [SYN_W-1:0]            req_syn,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic                               req_hit,
  input  logic [BANK_W-1:0]                  req_bank,
  input  logic                               sym_layout,
  input  logic                               tbl_wr_en,
  input  logic                               tbl_wr_pin,
  input  logic                               tbl_wr_set,
  input  logic [$clog2(QW_NUM*QW_BITS)-1:0]  tbl_wr_addr,
  input  logic [PIN_W-1:0]                   tbl_wr_data,
  output logic                               loc_valid,
  output logic                               loc_unknown,
  output logic                               loc_multi,
  output logic [$clog2(2*DIMMS_PER_GRP)-1:0] loc_dimm,
  output logic [PIN_W-1:0]                   loc_pin
);

  localparam int LINE_BITS = QW_NUM * QW_BITS;
  localparam int POS_W     = $clog2(LINE_BITS);
  localparam int QW_BYTES  = LINE_BYTES / QW_NUM;
  localparam int QW_LSB    = $clog2(QW_BYTES);
  localparam int QW_SEL_W  = $clog2(QW_NUM);
  localparam int GRP_SHIFT = $clog2(DIMMS_PER_GRP);
  localparam int DIMM_W    = $clog2(2 * DIMMS_PER_GRP);

  logic unused_bits;
  assign unused_bits = ^{req_addr[ADDR_W-1:QW_LSB+QW_SEL_W], req_addr[QW_LSB-1:0],
                         req_bank[BANK_W-1:1]};

  // ---------------- stage 1: classify and position ----------------
  loc_kind_e        kind_c;
  logic [POS_W-1:0] wil_c, where_c;

  ecc_syn_remap #(
    .SYN_W(SYN_W), .QW_BITS(QW_BITS), .QW_NUM(QW_NUM), .SYN_MAX(QW_BITS)
  ) u_remap (
    .syn(req_syn),
    .qw(req_addr[QW_LSB+QW_SEL_W-1:QW_LSB]),
    .hit(req_hit),
    .kind(kind_c),
    .wil(wil_c),
    .where_pos(where_c)
  );

  logic             s1_vld,   s1_vld_n;
  loc_kind_e        s1_kind,  s1_kind_n;
  logic             s1_grp,   s1_grp_n;
  logic             s1_set,   s1_set_n;
  logic [POS_W-1:0] s1_wil,   s1_wil_n;
  logic [POS_W-1:0] s1_where, s1_where_n;

  always_comb begin
    s1_vld_n   = req_valid;
    s1_kind_n  = s1_kind;
    s1_grp_n   = s1_grp;
    s1_set_n   = s1_set;
    s1_wil_n   = s1_wil;
    s1_where_n = s1_where;
    if (req_valid) begin
      s1_kind_n  = kind_c;
      s1_grp_n   = req_bank[0];
      s1_set_n   = ~sym_layout;
      s1_wil_n   = wil_c;
      s1_where_n = where_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_kind  <= LK_UNK;
      s1_grp   <= 1'b0;
      s1_set   <= 1'b0;
      s1_wil   <= '0;
      s1_where <= '0;
    end else begin
      s1_vld   <= s1_vld_n;
      s1_kind  <= s1_kind_n;
      s1_grp   <= s1_grp_n;
      s1_set   <= s1_set_n;
      s1_wil   <= s1_wil_n;
      s1_where <= s1_where_n;
    end
  end

  // ---------------- stage 2: table lookup ----------------
  logic             tbl_dimm_bit;
  logic [PIN_W-1:0] tbl_pin;

  ecc_loc_tables #(
    .LINE_BITS(LINE_BITS), .SLOTS(4), .SEL_BITS(2), .DATA_W(PIN_W), .NSETS(2)
  ) u_tables (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(tbl_wr_en),
    .wr_pin(tbl_wr_pin),
    .wr_set(tbl_wr_set),
    .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data),
    .rd_en(s1_vld && (s1_kind == LK_OK)),
    .rd_set(s1_set),
    .rd_where(s1_where),
    .rd_wil(s1_wil),
    .rd_dimm_bit(tbl_dimm_bit),
    .rd_pin(tbl_pin)
  );

  logic      s2_vld,  s2_vld_n;
  loc_kind_e s2_kind, s2_kind_n;
  logic      s2_grp,  s2_grp_n;

  always_comb begin
    s2_vld_n  = s1_vld;
    s2_kind_n = s2_kind;
    s2_grp_n  = s2_grp;
    if (s1_vld) begin
      s2_kind_n = s1_kind;
      s2_grp_n  = s1_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_kind <= LK_UNK;
      s2_grp  <= 1'b0;
    end else begin
      s2_vld  <= s2_vld_n;
      s2_kind <= s2_kind_n;
      s2_grp  <= s2_grp_n;
    end
  end

  // ---------------- result ----------------
  always_comb begin
    loc_valid   = s2_vld;
    loc_unknown = s2_vld && (s2_kind == LK_UNK);
    loc_multi   = s2_vld && (s2_kind == LK_MULTI);
    loc_dimm    = '0;
    loc_pin     = '0;
    if (s2_vld && (s2_kind != LK_UNK))
      loc_dimm = DIMM_W'({s2_grp, {GRP_SHIFT{1'b0}}});
    if (s2_vld && (s2_kind == LK_OK)) begin
      loc_dimm = loc_dimm | DIMM_W'(tbl_dimm_bit);
      loc_pin  = tbl_pin;
    end
  end

endmodule

// File: rtl/ecc_pin_locator_chk.sv
// Property checker for ecc_pin_locator, attached by bind.
module ecc_pin_locator_chk #(
  parameter int BANK_W = 2,
  parameter int DIMM_W = 3,
  parameter int PIN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_hit,
  input logic [BANK_W-1:0] req_bank,
  input logic              loc_valid,
  input logic              loc_unknown,
  input logic              loc_multi,
  input logic [DIMM_W-1:0] loc_dimm,
  input logic [PIN_W-1:0]  loc_pin
);

  // cycles since reset, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (loc_valid == $past(req_valid, 2)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_valid |-> (!loc_unknown && !loc_multi && loc_pin == '0 && loc_dimm == '0));

  assert_kind_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_unknown && loc_multi));

  assert_miss_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && loc_valid && !$past(req_hit, 2)) |-> loc_unknown);

  assert_unknown_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loc_unknown |-> (loc_dimm == '0 && loc_pin == '0));

  assert_multi_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && loc_multi) |->
      (loc_dimm[DIMM_W-2:0] == '0 && loc_dimm[DIMM_W-1] == $past(req_bank[0], 2)
       && loc_pin == '0));

  assert_group_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && loc_valid && !loc_unknown) |->
      (loc_dimm[DIMM_W-1] == $past(req_bank[0], 2) && loc_dimm[DIMM_W-2:1] == '0));

endmodule

bind ecc_pin_locator ecc_pin_locator_chk #(
  .BANK_W(BANK_W), .DIMM_W(DIMM_W), .PIN_W(PIN_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_hit(req_hit),
  .req_bank(req_bank),
  .loc_valid(loc_valid),
  .loc_unknown(loc_unknown),
  .loc_multi(loc_multi),
  .loc_dimm(loc_dimm),
  .loc_pin(loc_pin)
);

// File: tb/tb_ecc_pin_locator.sv
`timescale 1ns/1ps
module tb_ecc_pin_locator;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic signed [9:0] req_syn;
  logic [39:0]       req_addr;
  logic              req_hit;
  logic [1:0]        req_bank;
  logic              sym_layout;
  logic              tbl_wr_en;
  logic              tbl_wr_pin;
  logic              tbl_wr_set;
  logic [9:0]        tbl_wr_addr;
  logic [7:0]        tbl_wr_data;
  logic              loc_valid;
  logic              loc_unknown;
  logic              loc_multi;
  logic [2:0]        loc_dimm;
  logic [7:0]        loc_pin;

  always #2 clk = ~clk;

  ecc_pin_locator dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_syn(req_syn),
    .req_addr(req_addr), .req_hit(req_hit), .req_bank(req_bank),
    .sym_layout(sym_layout), .tbl_wr_en(tbl_wr_en), .tbl_wr_pin(tbl_wr_pin),
    .tbl_wr_set(tbl_wr_set), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .loc_valid(loc_valid), .loc_unknown(loc_unknown), .loc_multi(loc_multi),
    .loc_dimm(loc_dimm), .loc_pin(loc_pin)
  );

  // shadow of the tables, updated by the bench's own writes
  logic [7:0] sh_map [2][144];
  logic [7:0] sh_pin [2][576];

  // expected results in request order
  bit    e_unk   [2048];
  bit    e_multi [2048];
  int    e_dimm  [2048];
  int    e_pin   [2048];
  int    e_cyc   [2048];
  string e_tag   [2048];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: cycle %0d, expected completion before 100000", cyc);
      summary();
      $finish;
    end
  end

  // result monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && loc_valid) begin
      n_checks++;
      if (rd_ptr >= wr_ptr) begin
        n_fail++;
        $display("FAIL R1: result with no pending request, got valid=1 expected valid=0");
      end else begin
        if (loc_unknown !== e_unk[rd_ptr] || loc_multi !== e_multi[rd_ptr] ||
            int'(loc_dimm) != e_dimm[rd_ptr] || int'(loc_pin) != e_pin[rd_ptr] ||
            cyc != e_cyc[rd_ptr] + 2) begin
          n_fail++;
          $display("FAIL %s: req %0d got unk=%0b multi=%0b dimm=%0d pin=%0d cyc=%0d expected unk=%0b multi=%0b dimm=%0d pin=%0d cyc=%0d",
                   e_tag[rd_ptr], rd_ptr, loc_unknown, loc_multi, loc_dimm, loc_pin, cyc,
                   e_unk[rd_ptr], e_multi[rd_ptr], e_dimm[rd_ptr], e_pin[rd_ptr],
                   e_cyc[rd_ptr] + 2);
        end
        rd_ptr++;
      end
    end
  end

  task automatic quiet();
    req_valid = 1'b0; req_syn = '0; req_addr = '0; req_hit = 1'b0;
    req_bank = '0; sym_layout = 1'b0;
    tbl_wr_en = 1'b0; tbl_wr_pin = 1'b0; tbl_wr_set = 1'b0;
    tbl_wr_addr = '0; tbl_wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      quiet();
    end
  endtask

  task automatic tbl_write(input bit pin, input bit set, input int addr, input int data);
    @(negedge clk);
    quiet();
    tbl_wr_en = 1'b1; tbl_wr_pin = pin; tbl_wr_set = set;
    tbl_wr_addr = 10'(addr); tbl_wr_data = 8'(data);
    if (pin && addr < 576)  sh_pin[set][addr] = 8'(data);
    if (!pin && addr < 144) sh_map[set][addr] = 8'(data);
  endtask

  // expected result from the requirements (R2..R9)
  task automatic issue(input int syn, input int qw, input bit hit, input int bank,
                       input bit sym, input string tag_ok);
    int rem, wil, pos, setv, selb;
    @(negedge clk);
    quiet();
    req_valid = 1'b1; req_syn = 10'(syn); req_hit = hit;
    req_bank = 2'(bank); sym_layout = sym;
    req_addr = (40'(wr_ptr * 5 + 3) << 6) | 40'(qw << 4) | 40'(syn & 15);
    setv = sym ? 0 : 1;
    e_cyc[wr_ptr] = cyc;
    e_unk[wr_ptr] = 0; e_multi[wr_ptr] = 0; e_dimm[wr_ptr] = 0; e_pin[wr_ptr] = 0;
    if (!hit || syn < -1 || syn > 144) begin
      e_unk[wr_ptr] = 1; e_tag[wr_ptr] = "R2";
    end else if (syn == -1) begin
      e_multi[wr_ptr] = 1; e_dimm[wr_ptr] = (bank & 1) * 4; e_tag[wr_ptr] = "R3";
    end else begin
      if (syn < 128)      rem = syn + 16;
      else if (syn < 144) rem = syn - 137;
      else                rem = syn - 143;
      if (rem < 0 || rem > 143) begin
        e_unk[wr_ptr] = 1; e_tag[wr_ptr] = "R9";
      end else begin
        wil  = (3 - qw) * 144 + rem;
        pos  = 575 - wil;
        selb = (int'(sh_map[setv][pos / 4]) >> ((3 - pos % 4) * 2)) & 1;
        e_dimm[wr_ptr] = (bank & 1) * 4 + selb;
        e_pin[wr_ptr]  = int'(sh_pin[setv][wil]);
        e_tag[wr_ptr]  = tag_ok;
      end
    end
    wr_ptr++;
  endtask

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_checks++;
    if (loc_valid !== 1'b0 || loc_unknown !== 1'b0 || loc_multi !== 1'b0 ||
        loc_dimm !== 3'd0 || loc_pin !== 8'd0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0b u=%0b m=%0b dimm=%0d pin=%0d expected all 0",
               loc_valid, loc_unknown, loc_multi, loc_dimm, loc_pin);
    end

    // fill both table sets (R10)
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 144; i++) tbl_write(0, s[0], i, i * 37 + s * 91 + 5);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 576; w++) tbl_write(1, s[0], w, w * 7 + s * 53 + 3);

    // R10: a selector write beyond 143 must not alias onto byte 44 of set 0
    tbl_write(0, 0, 300, 8'hFF);
    idle(1);
    issue(94, 1, 1, 0, 1, "R10");

    // full sweep, back to back (R1 R4 R5 R6 R7 R8, with R2 R3 R9 corners)
    for (int sym = 0; sym < 2; sym++)
      for (int qw = 0; qw < 4; qw++)
        for (int syn = -3; syn <= 150; syn++)
          issue(syn, qw, ((syn + 20 + qw) % 13) != 0, (syn + qw + sym + 8) & 3,
                sym[0], sym ? "R4 R5 R6 R7 R8 set0" : "R4 R5 R6 R7 R8 set1");
    idle(3);

    // R11: write landing on the read edge returns old, next request returns new
    issue(10, 2, 1, 1, 1, "R11 old");
    tbl_write(1, 0, 170, ~int'(sh_pin[0][170]));
    issue(10, 2, 1, 1, 1, "R11 new");
    issue(-1, 0, 1, 3, 0, "R3");
    idle(4);

    // R1: every request produced exactly one result
    n_checks++;
    if (rd_ptr != wr_ptr) begin
      n_fail++;
      $display("FAIL R1 count: got %0d results expected %0d", rd_ptr, wr_ptr);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule